// File: doc/BRIEF.md
# SPI Controller Interrupt Status Unit

This unit keeps the three latched interrupt sources of an SPI controller: transfer complete, receive data ready and receive overflow. The transfer engine raises them with one-cycle pulses. Software clears them by writing ones to an interrupt-clear register. Each source is gated by an enable bit taken from the controller's control word. The gated result appears as a masked status value and as one level-sensitive interrupt line.

The enable bits do not sit at the same positions in the control word as the status bits they gate. The unit moves them into status order before masking.

The unit sees bus writes as a strobe, a register select and write data. Only the interrupt-clear select has an effect. Writes to the status, raw status and masked status selects leave the stored bits unchanged. Address decoding and FIFO handling live elsewhere in the controller.

Top module: `spi_irq_status`

## Requirements
- R1: After reset, all raw status bits are zero, the masked status is zero and `irq` is low.
- R2: A pulse on `frames_done` sets raw bit 0 (transfer complete) and raw bit 1 (receive ready) on the next clock edge.
- R3: A pulse on `rx_overflow` sets raw bit 2 (receive overflow) on the next clock edge.
- R4: A write with `wr_sel` = 0 (interrupt clear) clears every raw bit whose matching `wr_data` bit (bits 2:0) is 1. Raw bits whose `wr_data` bit is 0 keep their value.
- R5: Writes with `wr_sel` equal to 1, 2 or 3 (status, raw status, masked status) do not change the raw bits, whatever the data.
- R6: The masked status is formed in the same cycle from the raw bits and the control word: control bit 5 gates raw bit 0, control bit 4 gates raw bit 1, and control bit 6 gates raw bit 2. No other control bit has any effect.
- R7: `irq` is high exactly when at least one masked status bit is 1.
- R8: When a set pulse and a clear write hit the same raw bit in the same cycle, the bit ends up set.
- R9: Raw bits hold their value when there is no stimulus. Bits above bit 2 of both read values are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frames_done | input | 1 | Pulse: a group of frames has completed |
| rx_overflow | input | 1 | Pulse: a received frame found the receive FIFO full |
| ctrl_reg | input | DATA_W | Current control word, which carries the enable bits |
| wr_en | input | 1 | Bus write strobe |
| wr_sel | input | SEL_W | Register select: 0 clear, 1 status, 2 raw, 3 masked |
| wr_data | input | DATA_W | Bus write data |
| raw_rd | output | DATA_W | Raw status read value |
| masked_rd | output | DATA_W | Masked status read value |
| irq | output | 1 | Level interrupt output |

## Verification
The hardest case to reach is a clear write that lands in the same cycle as a set pulse on the same bit, because the port that sets and the port that clears are driven independently. The stimulus creates this collision deliberately, and it also spreads random collisions through a long random phase in which both pulses and clear writes fire often. A reference model in the bench predicts the raw bits every cycle. Control words that enable one source at a time confirm that each enable is remapped to the right status bit.

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
  parameter int DATA_W        = 32,
  parameter int SEL_W         = 2,
  parameter logic [SEL_W-1:0] SEL_CLEAR = '0,
  parameter int EN_TXDONE_POS = 5,
  parameter int EN_RXRDY_POS  = 4,
  parameter int EN_OVF_POS    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frames_done,
  input  logic              rx_overflow,
  input  logic [DATA_W-1:0] ctrl_reg,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] raw_rd,
  output logic [DATA_W-1:0] masked_rd,
  output logic              irq
);
  localparam int NSRC = 3;

  logic [NSRC-1:0] raw_q;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] enables;
  logic [NSRC-1:0] masked;

  assign set_vec = {rx_overflow, frames_done, frames_done};
  assign clr_vec = (wr_en && wr_sel == SEL_CLEAR) ? wr_data[NSRC-1:0] : '0;
  assign enables = {ctrl_reg[EN_OVF_POS], ctrl_reg[EN_RXRDY_POS], ctrl_reg[EN_TXDONE_POS]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (raw_q & ~clr_vec) | set_vec;
  end

  assign masked    = raw_q & enables;
  assign raw_rd    = {{(DATA_W-NSRC){1'b0}}, raw_q};
  assign masked_rd = {{(DATA_W-NSRC){1'b0}}, masked};
  assign irq       = |masked;
endmodule

// File: rtl/spi_irq_status_chk.sv
module spi_irq_status_chk #(
  parameter int DATA_W        = 32,
  parameter int SEL_W         = 2,
  parameter logic [SEL_W-1:0] SEL_CLEAR = '0,
  parameter int EN_TXDONE_POS = 5,
  parameter int EN_RXRDY_POS  = 4,
  parameter int EN_OVF_POS    = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frames_done,
  input logic              rx_overflow,
  input logic [DATA_W-1:0] ctrl_reg,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] raw_rd,
  input logic [DATA_W-1:0] masked_rd,
  input logic              irq
);
  logic [2:0] ref_en;
  assign ref_en = {ctrl_reg[EN_OVF_POS], ctrl_reg[EN_RXRDY_POS], ctrl_reg[EN_TXDONE_POS]};

  a_r2_frames_set: assert property (@(posedge clk) disable iff (!rst_n)
    frames_done |=> (raw_rd[0] && raw_rd[1]));

  a_r3_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |=> raw_rd[2]);

  a_r4_clear_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CLEAR && wr_data[0] && !frames_done) |=> !raw_rd[0]);

  a_r5_ro_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != SEL_CLEAR && !frames_done && !rx_overflow) |=> $stable(raw_rd));

  a_r6_mask_remap: assert property (@(posedge clk) disable iff (!rst_n)
    masked_rd[2:0] == (raw_rd[2:0] & ref_en));

  a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((raw_rd[2:0] & ref_en) != 3'b000));

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_rd[DATA_W-1:3] == '0) && (masked_rd[DATA_W-1:3] == '0));
endmodule

bind spi_irq_status spi_irq_status_chk #(
  .DATA_W(DATA_W), .SEL_W(SEL_W), .SEL_CLEAR(SEL_CLEAR),
  .EN_TXDONE_POS(EN_TXDONE_POS), .EN_RXRDY_POS(EN_RXRDY_POS), .EN_OVF_POS(EN_OVF_POS)
) u_chk (.*);

// File: tb/spi_irq_status_bench.sv
module spi_irq_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frames_done = 1'b0;
  logic        rx_overflow = 1'b0;
  logic [31:0] ctrl_reg = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] raw_rd, masked_rd;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  int m_raw = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_irq_status u_spi_irq_status (
    .clk(clk), .rst_n(rst_n), .frames_done(frames_done), .rx_overflow(rx_overflow),
    .ctrl_reg(ctrl_reg), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .raw_rd(raw_rd), .masked_rd(masked_rd), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compare every output with the reference model (R6, R7, R9 each cycle)
  task automatic compare(string raw_req);
    int en;
    int msk;
    en  = (ctrl_reg[5] ? 1 : 0) | (ctrl_reg[4] ? 2 : 0) | (ctrl_reg[6] ? 4 : 0);
    msk = m_raw & en;
    check(raw_req, raw_rd, 32'(m_raw));
    check("R6 masked", masked_rd, 32'(msk));
    check("R7 irq", {31'b0, irq}, {31'b0, (msk != 0)});
    check("R9 upper", {raw_rd[31:3], masked_rd[31:3]} == '0 ? 32'd0 : 32'd1, 32'd0);
  endtask

  // One clock: model follows the requirements, then compare at negedge
  task automatic step(string raw_req);
    @(posedge clk);
    if (wr_en && wr_sel == 2'd0) m_raw = m_raw & ~int'(wr_data[2:0]); // R4
    if (frames_done) m_raw = m_raw | 3;                                // R2, R8
    if (rx_overflow) m_raw = m_raw | 4;                                // R3, R8
    @(negedge clk);
    compare(raw_req);
    frames_done = 0; rx_overflow = 0; wr_en = 0;
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
  endtask

  initial begin
    #3000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1;
    @(negedge clk);
    compare("R1 after release");
    ctrl_reg = 32'h0000_0070;

    frames_done = 1; step("R2 frames_done");
    step("R9 hold");
    wr(2'd0, 32'h0000_0001); step("R4 clear bit0 only");
    rx_overflow = 1; step("R3 overflow");
    wr(2'd1, 32'hFFFF_FFFF); step("R5 status write");
    wr(2'd2, 32'hFFFF_FFFF); step("R5 raw write");
    wr(2'd3, 32'hFFFF_FFFF); step("R5 masked write");
    wr(2'd0, 32'hFFFF_FFF8); step("R4 zeros no effect");

    // R6: each enable alone, and all other control bits set
    ctrl_reg = 32'h0000_0020; @(negedge clk); compare("R6 en bit5");
    ctrl_reg = 32'h0000_0010; @(negedge clk); compare("R6 en bit4");
    ctrl_reg = 32'h0000_0040; @(negedge clk); compare("R6 en bit6");
    ctrl_reg = 32'hFFFF_FF8F; @(negedge clk); compare("R6 others");
    ctrl_reg = 32'h0000_0070;

    // R8: set and clear collide
    wr(2'd0, 32'h0000_0007); frames_done = 1; step("R8 set wins frames");
    wr(2'd0, 32'h0000_0007); rx_overflow = 1; step("R8 set wins ovf");
    wr(2'd0, 32'h0000_0007); step("R4 clear all");
    check("R7 irq low after clear", {31'b0, irq}, 32'd0);

    for (int i = 0; i < 400; i++) begin
      frames_done = ($urandom_range(3) == 0);
      rx_overflow = ($urandom_range(3) == 0);
      wr_en  = $urandom_range(1);
      wr_sel = 2'($urandom_range(3));
      wr_data = $urandom;
      if (i % 16 == 0) ctrl_reg = $urandom;
      step("R8 random");
    end

    rst_n = 0; #1; m_raw = 0;
    @(negedge clk); compare("R1 mid reset");
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule